// File: doc/BRIEF.md
# Time-Slot Interchange Output Channel Stage

This block is the output half of a time-slot interchange that serves eight serial streams of 32 byte-wide channels each. A frame is 256 bit-clock cycles long and starts at a frame pulse. For every output channel the block reads a 3-bit channel control word and an 8-bit channel word from two external connection stores. It then serialises one byte onto that stream, most significant bit first. In switched mode the byte comes from a data store, at the stream and channel named by the channel word. In message mode the byte is the channel word itself. The block also drives a per-stream output-enable and a per-stream control bit.

The three stores are outside the block and are read combinationally through address and data ports. The block makes one read of each store per bit cycle. During bit b of slot s it reads stream b, channel (s+1) mod 32. After eight cycles the bytes for every stream of the next slot are staged, and they move into the output shifters at the slot boundary. A global broadcast input forces every channel into message mode and enables it. A drive-enable input turns all outputs off at once. The block is meant to be tiled: several devices can share output streams by leaving their idle channels undriven.

Top module: `tsi_out_ctrl`

## Requirements
- R1: A frame pulse sampled on edge E0 makes the cycle after E0 bit 0 of slot 0. Slot c of every stream covers the 8 cycles after edges E(8c) to E(8c+7), with the byte sent most significant bit first. Aligned frame pulses come every 256 cycles.
- R2: When control bit 2 is 0 and the broadcast input is low, a channel sends the data-store byte at stream = channel word bits 7..5 and channel = channel word bits 4..0.
- R3: When control bit 2 is 1, a channel sends its own channel word byte.
- R4: When control bit 0 is 0 and the broadcast input is low, `sdo_oe` for that stream is low for the whole slot. When the bit is 1, `sdo_oe` is high for the whole slot.
- R5: While `out_drive_en` is low, every bit of `sdo_oe` is low in the same cycle, message mode included.
- R6: With `global_msg` high, every channel acts as if control bits 2 and 0 were both 1, whatever they hold.
- R7: `ctl_out` for a stream equals control bit 1 of the channel in the current slot, whatever the enable bit and `out_drive_en` hold.
- R8: During bit b of slot s, `cm_rd_stream` equals b and `cm_rd_chan` equals (s+1) mod 32.
- R9: While reset is asserted, `sdo`, `sdo_oe` and `ctl_out` are all zero.
- R10: A frame pulse that arrives when the counters are not at slot 31, bit 7 leaves slot 0 of the new frame undriven, with `ctl_out` at 0. Slots 1 to 31 of that frame carry their correct values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_pulse | input | 1 | One-cycle frame start marker |
| global_msg | input | 1 | Broadcast: force message mode and enable on all channels |
| out_drive_en | input | 1 | Global drive enable; low turns every output off |
| cm_rd_stream | output | 3 | Connection store read address, stream |
| cm_rd_chan | output | 5 | Connection store read address, channel |
| cmh_rdata | input | 3 | Control word: bit 0 enable, bit 1 control bit, bit 2 message |
| cml_rdata | input | 8 | Channel word: message byte or source stream/channel |
| dm_rd_stream | output | 3 | Data store read address, stream |
| dm_rd_chan | output | 5 | Data store read address, channel |
| dm_rdata | input | 8 | Data store read byte |
| sdo | output | 8 | Serial data, one bit per stream |
| sdo_oe | output | 8 | Output enable, one bit per stream |
| ctl_out | output | 8 | Control bit, one per stream |

## Verification
The assertions check the fetch address walk and its realignment on each frame pulse on every cycle. They also check that output enables and control bits change only at slot boundaries or frame pulses, and that the drive-enable input turns off all outputs. Only the bench scenarios can show which byte reaches which slot. This covers switched sources taken through a permutation, message bytes, per-channel disables, the broadcast override, and slot 0 going dark after a misaligned frame pulse. All of these depend on the contents of the external stores.

// File: rtl/tsi_pkg.sv
`timescale 1ns/1ps
package tsi_pkg;
    // Serial byte width; one stream is fetched per bit cycle, so it equals the stream count.
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned CMH_W   = 3;
    // Control word field positions.
    localparam int unsigned CMH_OE  = 0;
    localparam int unsigned CMH_CTL = 1;
    localparam int unsigned CMH_MSG = 2;
endpackage

// File: rtl/tsi_slot_timer.sv
`timescale 1ns/1ps
module tsi_slot_timer #(
    parameter  int unsigned BYTE_W   = 8,
    parameter  int unsigned CHANNELS = 32,
    localparam int unsigned BIT_W    = $clog2(BYTE_W),
    localparam int unsigned CHAN_W   = $clog2(CHANNELS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_pulse,
    output logic [BIT_W-1:0]  bit_idx,
    output logic [CHAN_W-1:0] chan_idx,
    output logic              slot_end,
    output logic              realign
);
    localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(BYTE_W - 1);
    localparam logic [CHAN_W-1:0] CHAN_LAST = CHAN_W'(CHANNELS - 1);

    typedef struct packed {
        logic [BIT_W-1:0]  bitc;
        logic [CHAN_W-1:0] chan;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic frame_end;

    always_comb begin
        tmr_d     = tmr_q;
        slot_end  = (tmr_q.bitc == BIT_LAST);
        frame_end = slot_end && (tmr_q.chan == CHAN_LAST);
        realign   = frame_pulse && !frame_end;
        if (frame_pulse) begin
            tmr_d.bitc = '0;
            tmr_d.chan = '0;
        end else if (slot_end) begin
            tmr_d.bitc = '0;
            tmr_d.chan = (tmr_q.chan == CHAN_LAST) ? '0 : tmr_q.chan + 1'b1;
        end else begin
            tmr_d.bitc = tmr_q.bitc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign bit_idx  = tmr_q.bitc;
    assign chan_idx = tmr_q.chan;
endmodule

// File: rtl/tsi_fetch.sv
`timescale 1ns/1ps
module tsi_fetch
    import tsi_pkg::*;
#(
    parameter  int unsigned STREAMS  = 8,
    parameter  int unsigned CHANNELS = 32,
    localparam int unsigned STREAM_W = $clog2(STREAMS),
    localparam int unsigned CHAN_W   = $clog2(CHANNELS)
) (
    input  logic [STREAM_W-1:0] slot_bit,
    input  logic [CHAN_W-1:0]   chan_idx,
    input  logic                global_msg,
    input  logic [CMH_W-1:0]    cmh_rdata,
    input  logic [BYTE_W-1:0]   cml_rdata,
    input  logic [BYTE_W-1:0]   dm_rdata,
    output logic [STREAM_W-1:0] rd_stream,
    output logic [CHAN_W-1:0]   rd_chan,
    output logic [STREAM_W-1:0] dm_stream,
    output logic [CHAN_W-1:0]   dm_chan,
    output logic [BYTE_W-1:0]   fetch_byte,
    output logic                fetch_drive,
    output logic                fetch_ctl
);
    localparam logic [CHAN_W-1:0] CHAN_LAST = CHAN_W'(CHANNELS - 1);

    logic msg_eff;

    always_comb begin
        // Look one slot ahead: bit b of slot s fetches stream b of slot s+1.
        rd_stream   = slot_bit;
        rd_chan     = (chan_idx == CHAN_LAST) ? '0 : chan_idx + 1'b1;
        dm_stream   = cml_rdata[BYTE_W-1 -: STREAM_W];
        dm_chan     = cml_rdata[CHAN_W-1:0];
        msg_eff     = cmh_rdata[CMH_MSG] | global_msg;
        fetch_drive = cmh_rdata[CMH_OE]  | global_msg;
        fetch_ctl   = cmh_rdata[CMH_CTL];
        fetch_byte  = msg_eff ? cml_rdata : dm_rdata;
    end
endmodule

// File: rtl/tsi_out_lane.sv
`timescale 1ns/1ps
module tsi_out_lane #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stage_we,
    input  logic              load,
    input  logic              clear,
    input  logic              ode,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              drive_in,
    input  logic              ctl_in,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              ctl
);
    typedef struct packed {
        logic [BYTE_W-1:0] stage_byte;
        logic              stage_drive;
        logic              stage_ctl;
        logic [BYTE_W-1:0] shift;
        logic              drive;
        logic              ctl;
    } lane_t;

    lane_t lane_d, lane_q;
    logic [BYTE_W-1:0] src_byte;
    logic              src_drive;
    logic              src_ctl;

    always_comb begin
        lane_d = lane_q;
        // A write in the loading cycle bypasses the stage register.
        src_byte  = stage_we ? byte_in  : lane_q.stage_byte;
        src_drive = stage_we ? drive_in : lane_q.stage_drive;
        src_ctl   = stage_we ? ctl_in   : lane_q.stage_ctl;
        if (stage_we) begin
            lane_d.stage_byte  = byte_in;
            lane_d.stage_drive = drive_in;
            lane_d.stage_ctl   = ctl_in;
        end
        if (clear) begin
            lane_d.shift = '0;
            lane_d.drive = 1'b0;
            lane_d.ctl   = 1'b0;
        end else if (load) begin
            lane_d.shift = src_byte;
            lane_d.drive = src_drive;
            lane_d.ctl   = src_ctl;
        end else begin
            lane_d.shift = {lane_q.shift[BYTE_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lane_q <= '0;
        else        lane_q <= lane_d;
    end

    assign sdo    = lane_q.shift[BYTE_W-1];
    assign sdo_oe = lane_q.drive & ode;
    assign ctl    = lane_q.ctl;
endmodule

// File: rtl/tsi_out_ctrl.sv
`timescale 1ns/1ps
module tsi_out_ctrl
    import tsi_pkg::*;
#(
    parameter  int unsigned STREAMS  = 8,
    parameter  int unsigned CHANNELS = 32,
    localparam int unsigned STREAM_W = $clog2(STREAMS),
    localparam int unsigned CHAN_W   = $clog2(CHANNELS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_pulse,
    input  logic                global_msg,
    input  logic                out_drive_en,
    output logic [STREAM_W-1:0] cm_rd_stream,
    output logic [CHAN_W-1:0]   cm_rd_chan,
    input  logic [CMH_W-1:0]    cmh_rdata,
    input  logic [BYTE_W-1:0]   cml_rdata,
    output logic [STREAM_W-1:0] dm_rd_stream,
    output logic [CHAN_W-1:0]   dm_rd_chan,
    input  logic [BYTE_W-1:0]   dm_rdata,
    output logic [STREAMS-1:0]  sdo,
    output logic [STREAMS-1:0]  sdo_oe,
    output logic [STREAMS-1:0]  ctl_out
);
    localparam int unsigned BIT_W = $clog2(BYTE_W);

    logic [BIT_W-1:0]   bit_idx;
    logic [CHAN_W-1:0]  chan_idx;
    logic               slot_end;
    logic               realign;
    logic [BYTE_W-1:0]  fetch_byte;
    logic               fetch_drive;
    logic               fetch_ctl;
    logic [STREAMS-1:0] lane_we;

    tsi_slot_timer #(
        .BYTE_W   (BYTE_W),
        .CHANNELS (CHANNELS)
    ) timer_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_pulse (frame_pulse),
        .bit_idx     (bit_idx),
        .chan_idx    (chan_idx),
        .slot_end    (slot_end),
        .realign     (realign)
    );

    tsi_fetch #(
        .STREAMS  (STREAMS),
        .CHANNELS (CHANNELS)
    ) fetch_i (
        .slot_bit    (bit_idx),
        .chan_idx    (chan_idx),
        .global_msg  (global_msg),
        .cmh_rdata   (cmh_rdata),
        .cml_rdata   (cml_rdata),
        .dm_rdata    (dm_rdata),
        .rd_stream   (cm_rd_stream),
        .rd_chan     (cm_rd_chan),
        .dm_stream   (dm_rd_stream),
        .dm_chan     (dm_rd_chan),
        .fetch_byte  (fetch_byte),
        .fetch_drive (fetch_drive),
        .fetch_ctl   (fetch_ctl)
    );

    for (genvar g = 0; g < STREAMS; g++) begin : g_lane
        assign lane_we[g] = (bit_idx == BIT_W'(g));

        tsi_out_lane #(
            .BYTE_W (BYTE_W)
        ) lane_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .stage_we (lane_we[g]),
            .load     (slot_end),
            .clear    (realign),
            .ode      (out_drive_en),
            .byte_in  (fetch_byte),
            .drive_in (fetch_drive),
            .ctl_in   (fetch_ctl),
            .sdo      (sdo[g]),
            .sdo_oe   (sdo_oe[g]),
            .ctl      (ctl_out[g])
        );
    end
endmodule

// File: rtl/tsi_out_ctrl_chk.sv
`timescale 1ns/1ps
module tsi_out_ctrl_chk #(
    parameter  int unsigned STREAMS  = 8,
    parameter  int unsigned CHANNELS = 32,
    localparam int unsigned STREAM_W = $clog2(STREAMS),
    localparam int unsigned CHAN_W   = $clog2(CHANNELS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                frame_pulse,
    input logic                out_drive_en,
    input logic [STREAM_W-1:0] cm_rd_stream,
    input logic [CHAN_W-1:0]   cm_rd_chan,
    input logic [STREAMS-1:0]  sdo_oe,
    input logic [STREAMS-1:0]  ctl_out
);
    localparam logic [STREAM_W-1:0] STREAM_LAST = STREAM_W'(STREAMS - 1);

    // R1: a frame pulse restarts the fetch at stream 0 of slot 1.
    p_frame_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |=> (cm_rd_stream == '0 && cm_rd_chan == CHAN_W'(1)));

    // R8: inside a slot the stream address steps by one and the channel holds.
    p_fetch_walk_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_pulse && cm_rd_stream != STREAM_LAST) |=>
        (cm_rd_stream == STREAM_W'($past(cm_rd_stream) + 1'b1) && $stable(cm_rd_chan)));

    // R5: drive enable low turns every output off.
    p_drive_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !out_drive_en |-> (sdo_oe == '0));

    // R4: enables change only at slot boundaries or frame pulses.
    p_oe_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_rd_stream != '0 && $stable(out_drive_en) && !$past(frame_pulse)) |-> $stable(sdo_oe));

    // R7: control bits change only at slot boundaries or frame pulses.
    p_ctl_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_rd_stream != '0 && !$past(frame_pulse)) |-> $stable(ctl_out));
endmodule

bind tsi_out_ctrl tsi_out_ctrl_chk #(
    .STREAMS  (STREAMS),
    .CHANNELS (CHANNELS)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_pulse  (frame_pulse),
    .out_drive_en (out_drive_en),
    .cm_rd_stream (cm_rd_stream),
    .cm_rd_chan   (cm_rd_chan),
    .sdo_oe       (sdo_oe),
    .ctl_out      (ctl_out)
);

// File: tb/tsi_out_ctrl_tb_top.sv
`timescale 1ns/1ps
module tsi_out_ctrl_tb_top;
    localparam int NS = 8;
    localparam int NC = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_pulse = 1'b0;
    logic       global_msg = 1'b0;
    logic       out_drive_en = 1'b1;
    logic [2:0] cm_rd_stream, dm_rd_stream;
    logic [4:0] cm_rd_chan, dm_rd_chan;
    logic [2:0] cmh_rdata;
    logic [7:0] cml_rdata, dm_rdata;
    logic [7:0] sdo, sdo_oe, ctl_out;

    logic [2:0] cmh_m [NS][NC];
    logic [7:0] cml_m [NS][NC];
    logic [7:0] dm_m  [NS][NC];

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    assign cmh_rdata = cmh_m[cm_rd_stream][cm_rd_chan];
    assign cml_rdata = cml_m[cm_rd_stream][cm_rd_chan];
    assign dm_rdata  = dm_m[dm_rd_stream][dm_rd_chan];

    tsi_out_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_pulse  (frame_pulse),
        .global_msg   (global_msg),
        .out_drive_en (out_drive_en),
        .cm_rd_stream (cm_rd_stream),
        .cm_rd_chan   (cm_rd_chan),
        .cmh_rdata    (cmh_rdata),
        .cml_rdata    (cml_rdata),
        .dm_rd_stream (dm_rd_stream),
        .dm_rd_chan   (dm_rd_chan),
        .dm_rdata     (dm_rdata),
        .sdo          (sdo),
        .sdo_oe       (sdo_oe),
        .ctl_out      (ctl_out)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(int s, int c);
        logic [7:0] w;
        w = cml_m[s][c];
        if (cmh_m[s][c][2] || global_msg) return w;
        return dm_m[w[7:5]][w[4:0]];
    endfunction

    function automatic bit exp_oe(int s, int c);
        return (cmh_m[s][c][0] | global_msg) & out_drive_en;
    endfunction

    // Entered and left at a negedge; issues one frame pulse and watches 256 cycles.
    task automatic run_frame(input bit do_check, input string req, input bit slot0_dark);
        logic [7:0] acc [NS];
        logic       oe0 [NS];
        logic       cs0 [NS];
        bit         bad [NS];
        frame_pulse = 1'b1;
        @(negedge clk);
        frame_pulse = 1'b0;
        for (int k = 0; k < 256; k++) begin
            int c = k / 8;
            int b = k % 8;
            for (int s = 0; s < NS; s++) begin
                if (b == 0) begin
                    acc[s] = '0;
                    oe0[s] = sdo_oe[s];
                    cs0[s] = ctl_out[s];
                    bad[s] = 0;
                end
                acc[s] = {acc[s][6:0], sdo[s]};
                if (sdo_oe[s] != oe0[s] || ctl_out[s] != cs0[s]) bad[s] = 1;
            end
            if (do_check && b == 3)
                chk(cm_rd_stream == 3'd3 && cm_rd_chan == 5'((c + 1) % NC), "R8", "fetch address",
                    {cm_rd_stream, cm_rd_chan}, {3'd3, 5'((c + 1) % NC)});
            if (do_check && b == 7) begin
                for (int s = 0; s < NS; s++) begin
                    bit eo;
                    bit ecs;
                    eo  = (slot0_dark && c == 0) ? 1'b0 : exp_oe(s, c);
                    ecs = (slot0_dark && c == 0) ? 1'b0 : cmh_m[s][c][1];
                    chk(!bad[s] && oe0[s] == eo, req, $sformatf("drive s%0d c%0d", s, c), int'(oe0[s]), int'(eo));
                    chk(!bad[s] && cs0[s] == ecs, "R7", $sformatf("ctl s%0d c%0d", s, c), int'(cs0[s]), int'(ecs));
                    if (eo)
                        chk(acc[s] == exp_byte(s, c), req, $sformatf("byte s%0d c%0d", s, c),
                            int'(acc[s]), int'(exp_byte(s, c)));
                end
            end
            if (k < 255) @(negedge clk);
        end
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk(sdo == '0 && sdo_oe == '0 && ctl_out == '0, "R9", "outputs in reset",
            {sdo, sdo_oe, ctl_out}, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_realign;
        for (int s = 0; s < NS; s++)
            for (int c = 0; c < NC; c++) begin
                cmh_m[s][c] = {1'b1, c[0], 1'b1};
                cml_m[s][c] = 8'(s * 29 + c * 3 + 1);
            end
        repeat (13) @(negedge clk);
        run_frame(1, "R10", 1);
    endtask

    task automatic t_switched;
        for (int s = 0; s < NS; s++)
            for (int c = 0; c < NC; c++) begin
                cmh_m[s][c] = {1'b0, c[1], 1'b1};
                cml_m[s][c] = {3'((s + 3) % NS), 5'((c * 7 + 5) % NC)};
                dm_m[s][c]  = 8'((s * 37 + c * 11) ^ 8'h5A);
            end
        run_frame(0, "", 0);
        run_frame(1, "R1 R2", 0);
    endtask

    task automatic t_mixed;
        for (int s = 0; s < NS; s++)
            for (int c = 0; c < NC; c++) begin
                cmh_m[s][c] = {c[0] ^ s[0], s[1], 1'b1};
                cml_m[s][c] = 8'(255 - s * 13 - c);
            end
        run_frame(0, "", 0);
        run_frame(1, "R3", 0);
    endtask

    task automatic t_disable;
        for (int s = 0; s < NS; s++)
            for (int c = 0; c < NC; c++)
                cmh_m[s][c] = {c[2], c[0], ((c + s) % 3) != 0};
        run_frame(0, "", 0);
        run_frame(1, "R4", 0);
    endtask

    task automatic t_drive_off;
        for (int s = 0; s < NS; s++)
            for (int c = 0; c < NC; c++)
                cmh_m[s][c] = {1'b1, c[3], 1'b1};
        run_frame(0, "", 0);
        out_drive_en = 1'b0;
        run_frame(1, "R5", 0);
        out_drive_en = 1'b1;
    endtask

    task automatic t_broadcast;
        for (int s = 0; s < NS; s++)
            for (int c = 0; c < NC; c++) begin
                cmh_m[s][c] = {1'b0, c[0] ^ c[2], 1'b0};
                cml_m[s][c] = 8'(s * 41 + c * 5 + 7);
            end
        global_msg = 1'b1;
        run_frame(0, "", 0);
        run_frame(1, "R6", 0);
        global_msg = 1'b0;
    endtask

    initial begin
        for (int s = 0; s < NS; s++)
            for (int c = 0; c < NC; c++) begin
                cmh_m[s][c] = '0;
                cml_m[s][c] = '0;
                dm_m[s][c]  = '0;
            end
        t_reset();
        t_realign();
        t_switched();
        t_mixed();
        t_disable();
        t_drive_off();
        t_broadcast();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule